// File: doc/BRIEF.md
# Looping Conversion Instruction Sequencer

This block steps an instruction pointer through a small instruction memory. For each word it asks an external conversion engine for one conversion and then waits for the engine's done pulse. A stop is decided per instruction and from configuration. A loop flag in the word sends the pointer back to address 0. A pause flag holds the sequencer before the word runs. Clearing the run flag lets the conversion in flight finish and then stops. Writing the clear flag abandons the sequence at once. Each finished conversion comes out with a one-cycle strobe, the engine's data and the address of the instruction that asked for it.

The states are IDLE (stopped), FETCH (the word at the pointer is inspected), CONV (the request is held until done) and PAUSED (held before a word whose pause flag is set). The transitions are: IDLE→FETCH when the run flag is set. FETCH→IDLE when the run flag is clear. FETCH→PAUSED when the pause flag is set, which also clears the run flag. FETCH→CONV otherwise. CONV→FETCH on done while the run flag is set. CONV→IDLE on done while the run flag is clear. PAUSED→CONV when the run flag is written to 1. Any state goes to IDLE on a clear write. Leaving PAUSED goes straight to CONV, so the paused word runs without its pause flag being looked at again. Interrupts raised by a downstream result store play no part in any transition.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the pointer reads 0, `conv_req` is low and `res_valid` is low.
- R2: A configuration write with `cfg_start`=1 and `cfg_clear`=0 while stopped starts execution at the current pointer. `conv_req` goes high with `conv_instr` equal to the word at the pointer and stays high until `conv_done` is seen.
- R3: On `conv_done` during a request, for a word whose loop flag (bit 1) is 0, the pointer advances by one, and 7 wraps to 0. With no loop flags set, all eight words run in turn continuously.
- R4: On `conv_done` during a request, for a word whose loop flag (bit 1) is 1, the pointer returns to 0.
- R5: A word whose pause flag (bit 0) is 1 is not issued when fetched. `conv_req` stays low and the pointer stays unchanged until `cfg_start`=1 is written again.
- R6: After a pause, writing `cfg_start`=1 issues the paused word itself, without checking its pause flag again.
- R7: Writing `cfg_start`=0 during a request keeps `conv_req` high until `conv_done`. That result is still delivered and the pointer still updates, and no further request follows.
- R8: A configuration write with `cfg_clear`=1 drops `conv_req` on the next cycle, sets the pointer to 0 and stops execution. A conversion in flight delivers no result.
- R9: The cycle after an accepted `conv_done`, `res_valid` is high for exactly one cycle. `res_tag` holds the address of the word that produced the result, and `res_data` holds `conv_data` as sampled with `conv_done`.
- R10: A configuration write with both `cfg_start`=1 and `cfg_clear`=1 leaves the sequencer stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_start | input | 1 | Run flag value written with `cfg_wr` |
| cfg_clear | input | 1 | Clear flag; a 1 written with `cfg_wr` stops the sequencer and zeroes the pointer |
| ram_we | input | 1 | Instruction memory write enable |
| ram_waddr | input | PTR_W | Instruction memory write address |
| ram_wdata | input | INSTR_W | Instruction word; bit 0 = pause, bit 1 = loop |
| conv_req | output | 1 | Conversion request, held until done |
| conv_instr | output | INSTR_W | Word at the current pointer |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| conv_data | input | DATA_W | Engine result, valid with `conv_done` |
| seq_ip | output | PTR_W | Current instruction pointer |
| res_valid | output | 1 | One-cycle result strobe |
| res_tag | output | PTR_W | Address of the word that produced the result |
| res_data | output | DATA_W | Captured result |

## Verification
The bench builds the block with its default parameters: 16-bit words, 16-bit data and a 3-bit pointer, which gives an eight-word memory. With eight words, the wrap from 7 to 0 is reached within ten conversions. Randomly placed loop and pause flags then produce many short loops, pauses on address 0 right after a wrap, and paused words that also loop. A few hundred random conversions cover all of these, and directed cases cover stopping during a request and the clear write.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int SEQ_PAUSE_BIT = 0;
    localparam int SEQ_LOOP_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_CONV   = 2'd2,
        ST_PAUSED = 2'd3
    } seq_state_e;
endpackage

// File: rtl/seq_instr_ram.sv
module seq_instr_ram #(
    parameter int PTR_W   = 3,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PTR_W-1:0]   waddr,
    input  logic [INSTR_W-1:0] wdata,
    input  logic [PTR_W-1:0]   raddr,
    output logic [INSTR_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [INSTR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/seq_ptr.sv
module seq_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             loop_flag,
    output logic [PTR_W-1:0] ip
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip <= '0;
        end else if (clear) begin
            ip <= '0;
        end else if (advance) begin
            if (loop_flag) begin
                ip <= '0;
            end else begin
                ip <= ip + PTR_W'(1);
            end
        end
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_start,
    input  logic cfg_clear,
    input  logic pause_flag,
    input  logic conv_done,
    output logic conv_req,
    output logic advance,
    output logic clear
);
    seq_state_e state, nxt;
    logic       run_q;

    assign clear = cfg_wr & cfg_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (cfg_wr) begin
            run_q <= cfg_start & ~cfg_clear;
        end else if (state == ST_FETCH && run_q && pause_flag) begin
            run_q <= 1'b0;
        end
    end

    always_comb begin
        nxt = state;
        if (clear) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (run_q) nxt = ST_FETCH;
                ST_FETCH: begin
                    if (!run_q)          nxt = ST_IDLE;
                    else if (pause_flag) nxt = ST_PAUSED;
                    else                 nxt = ST_CONV;
                end
                ST_CONV:   if (conv_done) nxt = run_q ? ST_FETCH : ST_IDLE;
                ST_PAUSED: if (run_q) nxt = ST_CONV;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        conv_req = (state == ST_CONV);
        advance  = (state == ST_CONV) && conv_done && !clear;
    end
endmodule

// File: rtl/seq_result.sv
module seq_result #(
    parameter int PTR_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [PTR_W-1:0]  ip,
    input  logic [DATA_W-1:0] conv_data,
    output logic              res_valid,
    output logic [PTR_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_tag   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= advance;
            if (advance) begin
                res_tag  <= ip;
                res_data <= conv_data;
            end
        end
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import seq_pkg::*;
#(
    parameter int PTR_W   = 3,
    parameter int INSTR_W = 16,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_start,
    input  logic               cfg_clear,
    input  logic               ram_we,
    input  logic [PTR_W-1:0]   ram_waddr,
    input  logic [INSTR_W-1:0] ram_wdata,
    output logic               conv_req,
    output logic [INSTR_W-1:0] conv_instr,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    output logic [PTR_W-1:0]   seq_ip,
    output logic               res_valid,
    output logic [PTR_W-1:0]   res_tag,
    output logic [DATA_W-1:0]  res_data
);
    logic advance, clear;

    seq_instr_ram #(.PTR_W(PTR_W), .INSTR_W(INSTR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
        .wdata(ram_wdata), .raddr(seq_ip), .rdata(conv_instr)
    );

    seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_clear(cfg_clear), .pause_flag(conv_instr[SEQ_PAUSE_BIT]),
        .conv_done(conv_done), .conv_req(conv_req), .advance(advance),
        .clear(clear)
    );

    seq_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
        .loop_flag(conv_instr[SEQ_LOOP_BIT]), .ip(seq_ip)
    );

    seq_result #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .advance(advance), .ip(seq_ip),
        .conv_data(conv_data), .res_valid(res_valid), .res_tag(res_tag),
        .res_data(res_data)
    );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_clear,
    input logic             conv_req,
    input logic             conv_done,
    input logic             loop_flag,
    input logic [PTR_W-1:0] ip,
    input logic             res_valid,
    input logic [PTR_W-1:0] res_tag
);
    logic past_ok;
    logic clr;

    assign clr = cfg_wr & cfg_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2 and R7: request held until done unless cleared
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done && !clr) |=> conv_req);

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done && !loop_flag && !clr) |=> (ip == $past(ip) + PTR_W'(1)));

    assert_loop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done && loop_flag && !clr) |=> (ip == '0));

    assert_clear_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!conv_req && ip == '0 && !res_valid));

    assert_result_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && res_valid) |-> ($past(conv_req && conv_done) && res_tag == $past(ip)));

    // R5: pointer only moves on an accepted done or a clear
    assert_ip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ip != $past(ip)) |-> ($past(conv_req && conv_done) || $past(clr)));
endmodule

bind conv_sequencer seq_checker #(.PTR_W(PTR_W)) u_seq_checker (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_clear(cfg_clear),
    .conv_req(conv_req), .conv_done(conv_done),
    .loop_flag(conv_instr[seq_pkg::SEQ_LOOP_BIT]), .ip(seq_ip),
    .res_valid(res_valid), .res_tag(res_tag)
);

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W   = 3;
    localparam int INSTR_W = 16;
    localparam int DATA_W  = 16;
    localparam int DEPTH   = 1 << PTR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_start = 1'b0, cfg_clear = 1'b0;
    logic ram_we = 1'b0;
    logic [PTR_W-1:0] ram_waddr = '0;
    logic [INSTR_W-1:0] ram_wdata = '0;
    logic conv_req;
    logic [INSTR_W-1:0] conv_instr;
    logic conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic [PTR_W-1:0] seq_ip;
    logic res_valid;
    logic [PTR_W-1:0] res_tag;
    logic [DATA_W-1:0] res_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [INSTR_W-1:0] shadow [DEPTH];
    logic [PTR_W-1:0] exp_ip;
    bit resumed;

    conv_sequencer #(.PTR_W(PTR_W), .INSTR_W(INSTR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_clear(cfg_clear), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .conv_req(conv_req), .conv_instr(conv_instr),
        .conv_done(conv_done), .conv_data(conv_data), .seq_ip(seq_ip),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PTR_W-1:0] next_ip(input logic [PTR_W-1:0] ip, input logic [INSTR_W-1:0] w);
        return w[1] ? '0 : ip + PTR_W'(1);
    endfunction

    task automatic cfg_write(input bit start, input bit clr);
        cfg_wr = 1'b1; cfg_start = start; cfg_clear = clr;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_start = 1'b0; cfg_clear = 1'b0;
    endtask

    task automatic ram_write(input logic [PTR_W-1:0] a, input logic [INSTR_W-1:0] d);
        ram_we = 1'b1; ram_waddr = a; ram_wdata = d;
        @(negedge clk);
        ram_we = 1'b0;
        shadow[a] = d;
    endtask

    task automatic wait_req(input string req);
        for (int i = 0; i < 20; i++) begin
            if (conv_req) break;
            @(negedge clk);
        end
        chk(conv_req == 1'b1, req, 32'(conv_req), 1);
    endtask

    task automatic do_conv(input logic [DATA_W-1:0] d, input logic [PTR_W-1:0] tag);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
        chk(res_valid == 1'b1, "R9 valid", 32'(res_valid), 1);
        chk(res_tag == tag, "R9 tag", 32'(res_tag), 32'(tag));
        chk(res_data == d, "R9 data", 32'(res_data), 32'(d));
        @(negedge clk);
        chk(res_valid == 1'b0, "R9 one cycle", 32'(res_valid), 0);
    endtask

    task automatic run_one();
        logic [DATA_W-1:0] d;
        if (shadow[exp_ip][0] && !resumed) begin
            repeat (6) @(negedge clk);
            chk(conv_req == 1'b0, "R5 held", 32'(conv_req), 0);
            chk(seq_ip == exp_ip, "R5 ip", 32'(seq_ip), 32'(exp_ip));
            cfg_write(1'b1, 1'b0);
            resumed = 1;
        end
        wait_req(resumed ? "R6 resume" : "R2 issue");
        chk(conv_instr == shadow[exp_ip], "R2 instr", 32'(conv_instr), 32'(shadow[exp_ip]));
        repeat ($urandom % 4) @(negedge clk);
        chk(conv_req == 1'b1, "R2 hold", 32'(conv_req), 1);
        d = DATA_W'($urandom);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
        chk(res_valid == 1'b1, "R9 valid", 32'(res_valid), 1);
        chk(res_tag == exp_ip, "R9 tag", 32'(res_tag), 32'(exp_ip));
        chk(res_data == d, "R9 data", 32'(res_data), 32'(d));
        exp_ip = next_ip(exp_ip, shadow[exp_ip]);
        chk(seq_ip == exp_ip, "R3/R4 ip", 32'(seq_ip), 32'(exp_ip));
        resumed = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        exp_ip = '0; resumed = 0;
        repeat (3) @(negedge clk);
        chk(seq_ip == '0, "R1 ip", 32'(seq_ip), 0);
        chk(conv_req == 1'b0, "R1 req", 32'(conv_req), 0);
        chk(res_valid == 1'b0, "R1 valid", 32'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seq_ip == '0 && !conv_req && !res_valid, "R1 after release", 32'(conv_req), 0);

        // R3: plain program, full wrap
        cfg_write(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) run_one();

        // R7: stop during request
        wait_req("R7 issue");
        cfg_write(1'b0, 1'b0);
        chk(conv_req == 1'b1, "R7 still requesting", 32'(conv_req), 1);
        do_conv(DATA_W'(16'hA5C3), exp_ip);
        exp_ip = next_ip(exp_ip, shadow[exp_ip]);
        repeat (8) @(negedge clk);
        chk(conv_req == 1'b0, "R7 stopped", 32'(conv_req), 0);
        chk(seq_ip == exp_ip, "R7 ip", 32'(seq_ip), 32'(exp_ip));
        cfg_write(1'b1, 1'b0);
        for (int i = 0; i < 2; i++) run_one();

        // R8: clear during request
        wait_req("R8 issue");
        cfg_write(1'b0, 1'b1);
        chk(conv_req == 1'b0, "R8 req", 32'(conv_req), 0);
        chk(seq_ip == '0, "R8 ip", 32'(seq_ip), 0);
        chk(res_valid == 1'b0, "R8 no result", 32'(res_valid), 0);
        repeat (6) @(negedge clk);
        chk(conv_req == 1'b0, "R8 stays stopped", 32'(conv_req), 0);
        exp_ip = '0;

        // R4, R5, R6: loop at 2, pause at 1
        ram_write(3'd1, 16'h1231);
        ram_write(3'd2, 16'h4562);
        cfg_write(1'b1, 1'b0);
        for (int i = 0; i < 7; i++) run_one();
        cfg_write(1'b0, 1'b1);
        exp_ip = '0;

        // R10: start together with clear
        cfg_write(1'b1, 1'b1);
        repeat (8) @(negedge clk);
        chk(conv_req == 1'b0, "R10 stopped", 32'(conv_req), 0);
        chk(seq_ip == '0, "R10 ip", 32'(seq_ip), 0);

        // random programs
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < DEPTH; a++) begin
                logic [INSTR_W-1:0] w;
                w = INSTR_W'($urandom);
                w[1] = ($urandom % 4) == 0;
                w[0] = ($urandom % 6) == 0;
                ram_write(PTR_W'(a), w);
            end
            exp_ip = '0; resumed = 0;
            cfg_write(1'b1, 1'b0);
            for (int i = 0; i < 80; i++) run_one();
            cfg_write(1'b0, 1'b1);
            chk(seq_ip == '0 && !conv_req, "R8 random clear", 32'(seq_ip), 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule